// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between an internal master and an external asynchronous bus with a 24-bit address and a 16-bit data path. The master asks for a byte, word or long-word read or write. The block runs as many external cycles as the responding port needs. Each cycle drives an address, a two-bit size code giving the bytes still to move, a read/write flag and a cycle strobe. It then waits for a two-bit acknowledge. The acknowledge either inserts a wait state, reports that the port is 8 or 16 bits wide for this cycle, or signals a bus error.

Port width is learned again on every cycle, so a single transfer may even see different widths cycle by cycle. Write bytes are steered onto the lane that a port of either width reads. Read bytes are shifted into a 32-bit holding register, most significant byte first. The master sees a one-cycle completion pulse only after the last external cycle is acknowledged, with the read result right-justified.

Word and long transfers must start at even addresses. A misaligned request or a reserved size code gets an immediate error response and runs no external cycle.

Top module: `dyn_bus_sizer`

## Requirements
- R1: While reset is high, and on the first cycle after it, ext_strobe, req_done and req_err are low.
- R2: During each external cycle, ext_siz holds the number of bytes still to move at its start: 01 = 1, 10 = 2, 11 = 3, 00 = 4. req_size uses 00 = byte, 01 = word, 10 = long.
- R3: A long word answered by a 16-bit port takes two cycles, at A and A+2. Answered by an 8-bit port it takes four cycles, at A, A+1, A+2 and A+3, with the most significant byte first.
- R4: On writes, an even ext_addr carries the current byte on ext_dout[15:8] and the following byte on ext_dout[7:0]. An odd ext_addr carries the current byte on both lanes. Either way, an 8-bit port finds its byte on [15:8].
- R5: On reads, an 8-bit port supplies its byte on ext_din[15:8]. A 16-bit port supplies the even byte on [15:8] and the odd byte on [7:0]. req_rdata holds the result right-justified, with unused upper bytes zero.
- R6: ext_ack = 00 inserts a wait state. ext_strobe, ext_addr, ext_siz and ext_dout hold their values until a non-zero code arrives.
- R7: req_done is a single-cycle pulse, given on the cycle after the final acknowledge of a transfer and never earlier.
- R8: After each non-final acknowledge, ext_strobe is low for exactly one cycle before the next external cycle starts.
- R9: ext_ack = 11 (bus error) ends the transfer at once. req_done and req_err are high together on the next cycle, and no further external cycle starts.
- R10: A word or long request at an odd address, or a request with req_size = 11, gives req_done and req_err on the next cycle with no external cycle.
- R11: ext_ack = 01 (8-bit port) moves one byte. ext_ack = 10 (16-bit port) moves two bytes, except at an odd address or with one byte left, where it moves one. This is decided again on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10 long, 11 reserved |
| req_addr | input | ADDR_W | Start byte address |
| req_wdata | input | 32 | Write data, right-justified |
| req_done | output | 1 | Completion pulse |
| req_err | output | 1 | Error flag, valid with req_done |
| req_rdata | output | 32 | Assembled read data, right-justified |
| ext_strobe | output | 1 | External cycle active |
| ext_rw | output | 1 | 1 = read, 0 = write |
| ext_addr | output | ADDR_W | External byte address |
| ext_siz | output | 2 | Bytes remaining code |
| ext_dout | output | 16 | Write data lanes |
| ext_din | input | 16 | Read data lanes |
| ext_ack | input | 2 | 00 wait, 01 8-bit, 10 16-bit, 11 error |

## Verification
An accepted request raises ext_strobe with the first address and size one clock after the accepting edge. Every non-wait acknowledge is sampled at a rising edge. On the next edge the strobe drops, and the updated address, size and lanes appear with it, or req_done pulses if the transfer is over. The next external cycle starts one edge after that. The bench drives requests and acknowledges at falling edges and reads every output at the following falling edge. Results are therefore checked exactly one register stage after the acknowledge that caused them, and wait, gap and done timing are counted in whole cycles.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANE_W   = 16;
  localparam int WORD_W   = 32;
  localparam int MAX_BYTE = WORD_W / 8;
  localparam int CNT_W    = $clog2(MAX_BYTE + 1);

  typedef enum logic [1:0] {
    ACK_WAIT  = 2'b00,
    ACK_P8    = 2'b01,
    ACK_P16   = 2'b10,
    ACK_FAULT = 2'b11
  } ack_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } req_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_GAP  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
  import dbs_pkg::*;
(
  input  logic [1:0]       ack,
  input  logic             addr_odd,
  input  logic [CNT_W-1:0] remain,
  output logic [1:0]       step,
  output logic             fault,
  output logic             port16
);
  always_comb begin
    step   = 2'd0;
    fault  = 1'b0;
    port16 = 1'b0;
    case (ack)
      ACK_P8:  step = 2'd1;
      ACK_P16: begin
        port16 = 1'b1;
        step   = (addr_odd || remain == CNT_W'(1)) ? 2'd1 : 2'd2;
      end
      ACK_FAULT: fault = 1'b1;
      default: step = 2'd0;
    endcase
  end
endmodule

// File: rtl/dbs_wr_steer.sv
module dbs_wr_steer
  import dbs_pkg::*;
(
  input  logic [WORD_W-1:0] shreg,
  input  logic              addr_odd,
  output logic [LANE_W-1:0] lanes
);
  logic [7:0] cur_byte;
  logic [7:0] nxt_byte;

  assign cur_byte = shreg[WORD_W-1 -: 8];
  assign nxt_byte = shreg[WORD_W-9 -: 8];

  always_comb begin
    if (addr_odd) lanes = {cur_byte, cur_byte};
    else          lanes = {cur_byte, nxt_byte};
  end
endmodule

// File: rtl/dbs_rd_pack.sv
module dbs_rd_pack
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [1:0]        step,
  input  logic              addr_odd,
  input  logic              port16,
  input  logic [LANE_W-1:0] din,
  output logic [WORD_W-1:0] hold
);
  logic [7:0] one_byte;

  assign one_byte = (port16 && addr_odd) ? din[7:0] : din[15:8];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold <= '0;
    end else if (take) begin
      if (step == 2'd2) hold <= {hold[WORD_W-LANE_W-1:0], din};
      else if (step == 2'd1) hold <= {hold[WORD_W-9:0], one_byte};
    end
  end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [31:0]       req_rdata,
  output logic              ext_strobe,
  output logic              ext_rw,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [1:0]        ext_siz,
  output logic [15:0]       ext_dout,
  input  logic [15:0]       ext_din,
  input  logic [1:0]        ext_ack
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  remain_q;
  logic [WORD_W-1:0] wsh_q;

  logic [1:0]        step;
  logic              fault;
  logic              port16;
  logic              accept;
  logic              bad_req;
  logic              take;
  logic [CNT_W-1:0]  init_cnt;
  logic [WORD_W-1:0] init_wsh;
  logic [CNT_W-1:0]  remain_n;
  logic [ADDR_W-1:0] addr_n;
  logic [WORD_W-1:0] wsh_n;
  logic [ADDR_W-1:0] lane_addr;
  logic [WORD_W-1:0] lane_src;
  logic [LANE_W-1:0] lanes;

  dbs_step_calc u_step (
    .ack      (ext_ack),
    .addr_odd (ext_addr[0]),
    .remain   (remain_q),
    .step     (step),
    .fault    (fault),
    .port16   (port16)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign bad_req = (req_size == SZ_RSVD) || ((req_size != SZ_BYTE) && req_addr[0]);
  assign take    = (state_q == ST_RUN) && (step != 2'd0) && ext_rw;

  always_comb begin
    case (req_size)
      SZ_WORD: begin
        init_cnt = CNT_W'(2);
        init_wsh = {req_wdata[15:0], 16'h0000};
      end
      SZ_LONG: begin
        init_cnt = CNT_W'(4);
        init_wsh = req_wdata;
      end
      default: begin
        init_cnt = CNT_W'(1);
        init_wsh = {req_wdata[7:0], 24'h000000};
      end
    endcase
  end

  assign remain_n = remain_q - CNT_W'(step);
  assign addr_n   = ext_addr + ADDR_W'(step);
  assign wsh_n    = (step == 2'd2) ? {wsh_q[WORD_W-17:0], 16'h0000}
                  : (step == 2'd1) ? {wsh_q[WORD_W-9:0], 8'h00}
                  : wsh_q;

  assign lane_addr = (state_q == ST_IDLE) ? req_addr : addr_n;
  assign lane_src  = (state_q == ST_IDLE) ? init_wsh : wsh_n;

  dbs_wr_steer u_steer (
    .shreg    (lane_src),
    .addr_odd (lane_addr[0]),
    .lanes    (lanes)
  );

  dbs_rd_pack u_pack (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .take     (take),
    .step     (step),
    .addr_odd (ext_addr[0]),
    .port16   (port16),
    .din      (ext_din),
    .hold     (req_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      remain_q   <= '0;
      wsh_q      <= '0;
      ext_strobe <= 1'b0;
      ext_rw     <= 1'b1;
      ext_addr   <= '0;
      ext_siz    <= 2'b00;
      ext_dout   <= '0;
      req_done   <= 1'b0;
      req_err    <= 1'b0;
    end else begin
      req_done <= 1'b0;
      req_err  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (bad_req) begin
              req_done <= 1'b1;
              req_err  <= 1'b1;
            end else begin
              state_q    <= ST_RUN;
              remain_q   <= init_cnt;
              wsh_q      <= init_wsh;
              ext_strobe <= 1'b1;
              ext_rw     <= ~req_write;
              ext_addr   <= req_addr;
              ext_siz    <= init_cnt[1:0];
              ext_dout   <= lanes;
            end
          end
        end
        ST_RUN: begin
          if (fault) begin
            ext_strobe <= 1'b0;
            req_done   <= 1'b1;
            req_err    <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (step != 2'd0) begin
            ext_strobe <= 1'b0;
            remain_q   <= remain_n;
            wsh_q      <= wsh_n;
            if (remain_n == '0) begin
              req_done <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              ext_addr <= addr_n;
              ext_siz  <= remain_n[1:0];
              ext_dout <= lanes;
              state_q  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          ext_strobe <= 1'b1;
          state_q    <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dyn_bus_sizer_checker.sv
module dyn_bus_sizer_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_strobe,
  input logic [1:0]        ext_ack,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [1:0]        ext_siz,
  input logic [15:0]       ext_dout,
  input logic              req_done,
  input logic              req_err
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ext_strobe && !req_done && !req_err)); // R1
  AST_FOUR_EVEN: assert property (@(posedge clk) disable iff (rst) (ext_strobe && ext_siz == 2'b00) |-> !ext_addr[0]); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst) (ext_strobe && ext_ack == 2'b00) |=> (ext_strobe && $stable(ext_addr) && $stable(ext_siz) && $stable(ext_dout))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) req_done |=> !req_done); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst) req_err |-> req_done); // R9
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) (ext_strobe && ext_ack != 2'b00) |=> !ext_strobe); // R8
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (rst) (ext_strobe && ext_ack == 2'b11) |=> (req_done && req_err)); // R9
endmodule

bind dyn_bus_sizer dyn_bus_sizer_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ext_strobe (ext_strobe),
  .ext_ack    (ext_ack),
  .ext_addr   (ext_addr),
  .ext_siz    (ext_siz),
  .ext_dout   (ext_dout),
  .req_done   (req_done),
  .req_err    (req_err)
);

// File: tb/dyn_bus_sizer_tb_top.sv
module dyn_bus_sizer_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_done, req_err;
  logic [31:0]   req_rdata;
  logic          ext_strobe, ext_rw;
  logic [AW-1:0] ext_addr;
  logic [1:0]    ext_siz;
  logic [15:0]   ext_dout;
  logic [15:0]   ext_din = '0;
  logic [1:0]    ext_ack = 2'b00;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0]    mem [256];
  logic [AW-1:0] log_addr [8];
  logic [1:0]    log_siz [8];
  int            n_cyc;
  int            gap_bad;
  int            hold_bad;
  int            early_done;
  logic          got_err;
  logic [31:0]   got_rdata;

  always #2 clk = ~clk;

  dyn_bus_sizer #(.ADDR_W(AW)) dut_i (.*);

  function automatic logic [7:0] rd_val(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  // pat holds one 2-bit acknowledge code per external cycle; waits = wait states per cycle
  task automatic run_xfer(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, input logic [15:0] pat, input int waits);
    bit pend = 0;
    bit seen_gap = 0;
    int waitc = 0;
    int lowc = 0;
    logic [AW-1:0] s_addr;
    logic [1:0] s_siz;
    logic [15:0] s_dout;
    logic [1:0] code;
    n_cyc = 0; gap_bad = 0; hold_bad = 0; early_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 300; g++) begin
      if (pend) begin
        n_cyc++; pend = 0; ext_ack = 2'b00; waitc = 0; lowc = 0; seen_gap = 1;
      end
      if (req_done) begin
        got_err = req_err; got_rdata = req_rdata;
        break;
      end
      if (ext_strobe) begin
        if (seen_gap && lowc != 1) gap_bad++;
        seen_gap = 0;
        if (waitc == 0) begin
          s_addr = ext_addr; s_siz = ext_siz; s_dout = ext_dout;
          if (n_cyc < 8) begin log_addr[n_cyc] = ext_addr; log_siz[n_cyc] = ext_siz; end
        end else if (s_addr !== ext_addr || s_siz !== ext_siz || s_dout !== ext_dout) begin
          hold_bad++;
        end
        if (waitc < waits) begin
          ext_ack = 2'b00; waitc++;
        end else begin
          code = pat[2*n_cyc +: 2];
          ext_ack = code; pend = 1;
          if (code == 2'b01) begin
            ext_din = {rd_val(ext_addr), 8'h00};
            if (!ext_rw) mem[ext_addr[7:0]] = ext_dout[15:8];
          end else if (code == 2'b10) begin
            ext_din = {rd_val({ext_addr[AW-1:1], 1'b0}), rd_val({ext_addr[AW-1:1], 1'b1})};
            if (!ext_rw) begin
              if (ext_addr[0]) mem[ext_addr[7:0]] = ext_dout[7:0];
              else if (ext_siz == 2'b01) mem[ext_addr[7:0]] = ext_dout[15:8];
              else begin
                mem[ext_addr[7:0]] = ext_dout[15:8];
                mem[ext_addr[7:0] + 8'd1] = ext_dout[7:0];
              end
            end
          end
        end
      end else begin
        lowc++;
      end
      @(negedge clk);
    end
    ext_ack = 2'b00;
    @(negedge clk);
    if (req_done) early_done++;
  endtask

  task automatic t_reset();
    chk("R1 strobe", 32'(ext_strobe), 0);
    chk("R1 done", 32'(req_done), 0);
    chk("R1 err", 32'(req_err), 0);
  endtask

  task automatic t_long_p16_read();
    run_xfer(1'b0, 2'b10, 24'h000040, 0, 16'h00AA, 0);
    chk("R3 cycles p16", n_cyc, 2);
    chk("R3 addr0", log_addr[0], 24'h40);
    chk("R3 addr1", log_addr[1], 24'h42);
    chk("R2 siz0", 32'(log_siz[0]), 2'b00);
    chk("R2 siz1", 32'(log_siz[1]), 2'b10);
    chk("R5 long p16 data", got_rdata, {rd_val(24'h40), rd_val(24'h41), rd_val(24'h42), rd_val(24'h43)});
    chk("R7 done single", early_done, 0);
    chk("R8 gap", gap_bad, 0);
  endtask

  task automatic t_long_p8_write();
    clear_mem();
    run_xfer(1'b1, 2'b10, 24'h000010, 32'hC1D2E3F4, 16'h0055, 0);
    chk("R3 cycles p8", n_cyc, 4);
    chk("R3 p8 addr3", log_addr[3], 24'h13);
    chk("R2 siz p8", {log_siz[0], log_siz[1], log_siz[2], log_siz[3]}, 8'b00_11_10_01);
    chk("R4 p8 bytes", {mem[16], mem[17], mem[18], mem[19]}, 32'hC1D2E3F4);
    chk("R9 no err", 32'(got_err), 0);
    chk("R8 gap p8", gap_bad, 0);
  endtask

  task automatic t_word_p16_write_waits();
    clear_mem();
    run_xfer(1'b1, 2'b01, 24'h000020, 32'h0000BEEF, 16'h0002, 3);
    chk("R6 held in waits", hold_bad, 0);
    chk("R6 one cycle", n_cyc, 1);
    chk("R4 word even lanes", {mem[32], mem[33]}, 16'hBEEF);
    chk("R2 word siz", 32'(log_siz[0]), 2'b10);
  endtask

  task automatic t_odd_byte();
    clear_mem();
    run_xfer(1'b1, 2'b00, 24'h000035, 32'h0000007E, 16'h0002, 1);
    chk("R4 odd byte p16 low lane", mem[53], 8'h7E);
    chk("R4 odd byte neighbour", mem[52], 8'h00);
    run_xfer(1'b0, 2'b00, 24'h000035, 0, 16'h0002, 0);
    chk("R5 odd byte p16 read", got_rdata, {24'h0, rd_val(24'h35)});
    run_xfer(1'b0, 2'b00, 24'h000035, 0, 16'h0001, 0);
    chk("R5 odd byte p8 read", got_rdata, {24'h0, rd_val(24'h35)});
    run_xfer(1'b0, 2'b01, 24'h000036, 0, 16'h0005, 2);
    chk("R5 word p8 read", got_rdata, {16'h0, rd_val(24'h36), rd_val(24'h37)});
  endtask

  task automatic t_mixed_ports();
    run_xfer(1'b0, 2'b10, 24'h000060, 0, 16'b10_10_01, 0);
    chk("R11 cycles", n_cyc, 3);
    chk("R11 addrs", {log_addr[0][7:0], log_addr[1][7:0], log_addr[2][7:0]}, 24'h606162);
    chk("R11 sizes", {log_siz[0], log_siz[1], log_siz[2]}, 6'b00_11_10);
    chk("R11 data", got_rdata, {rd_val(24'h60), rd_val(24'h61), rd_val(24'h62), rd_val(24'h63)});
  endtask

  task automatic t_fault();
    run_xfer(1'b0, 2'b10, 24'h000080, 0, 16'h0003, 1);
    chk("R9 cycles", n_cyc, 1);
    chk("R9 err", 32'(got_err), 1);
    chk("R9 strobe low", 32'(ext_strobe), 0);
  endtask

  task automatic t_misaligned();
    run_xfer(1'b0, 2'b01, 24'h000011, 0, 16'h0002, 0);
    chk("R10 odd word no cycle", n_cyc, 0);
    chk("R10 odd word err", 32'(got_err), 1);
    run_xfer(1'b0, 2'b11, 24'h000010, 0, 16'h0002, 0);
    chk("R10 reserved size no cycle", n_cyc, 0);
    chk("R10 reserved size err", 32'(got_err), 1);
    chk("R7 no trailing done", early_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_long_p16_read();
    t_long_p8_write();
    t_word_p16_write_waits();
    t_odd_byte();
    t_mixed_ports();
    t_fault();
    t_misaligned();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule